// File: doc/BRIEF.md
# Cascaded Flag-Bus Ownership Controller

This block sits in each device of a bank of cascaded FIFO devices whose narrow per-queue flag-status buses are wired together into one shared bus. It decides, cycle by cycle, whether this device drives that shared bus. When it does, it drives the per-queue flag values that arrive from the flag logic and turns on the per-bit output enables. When it does not, every enable is off so that another device can drive the bus.

Two ownership schemes exist, and the level of a mode pin seen while master reset is held picks one. In the addressed scheme a controller presents a device-select field together with a strobe; the device whose identity matches takes the bus one clock later, and any other addressed strobe releases it. In the ring scheme no controller is needed. One device is wired as ring master and takes the bus on the first clock after reset, marking that cycle with a sync pulse. Ownership then travels as a one-cycle token from each device's token output to the next device's token input, wrapping from the last device back to the first.

A queue-select operation on the same port must not coincide with an ownership selection. This block treats a strobe that arrives together with a queue select as void.

Top module: `flag_bus_owner`

## Requirements
- R1: The scheme is taken from `mode_i` on every clock edge while `rst_n` is low (0 = addressed, 1 = ring) and is held from the release of reset until the next reset; changes on `mode_i` after release have no effect.
- R2: While reset is held, and afterwards until the first ownership event, `flag_oe_o` is all zeros and `token_out_o` and `sync_o` are low; in addressed mode `token_out_o` and `sync_o` stay low at all times.
- R3: In addressed mode, a clock edge with `strobe_i` high, `qsel_i` low and `dev_addr_i` equal to `dev_id_i` makes the device the owner from the cycle after that edge, and `flag_oe_o` is then all ones.
- R4: In addressed mode, a valid strobe whose `dev_addr_i` differs from `dev_id_i` releases the bus from the next cycle; with `strobe_i` low, ownership is unchanged.
- R5: In addressed mode, a strobe on an edge where `qsel_i` is high is ignored: ownership stays as it was.
- R6: In ring mode, a device with `master_i` high owns the bus in the first cycle after reset is released, and `sync_o` is high in that cycle; a device with `master_i` low does not own it in that cycle, whatever its token input is.
- R7: In ring mode, after the first cycle, the device owns the bus in a cycle exactly when `token_in_i` was high at the preceding edge, and `token_out_o` is high exactly in the cycles it owns the bus.
- R8: `sync_o` is high only in ring mode, only on the device with `master_i` high, and only in cycles in which that device owns the bus.
- R9: When not owning, `flag_oe_o` and `flag_o` are all zeros; when owning, every bit of `flag_oe_o` is one and `flag_o` equals `flag_in_i` as sampled at the preceding edge.
- R10: Ownership can change on every consecutive clock in both schemes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| mode_i | input | 1 | Scheme pick, sampled during reset: 0 addressed, 1 ring |
| dev_id_i | input | ID_W (3) | Identity of this device in the bank |
| dev_addr_i | input | ID_W (3) | Device-select field of the port address bus |
| strobe_i | input | 1 | Ownership-selection strobe (addressed mode) |
| qsel_i | input | 1 | Queue selection in progress this cycle |
| master_i | input | 1 | High on the ring master device |
| token_in_i | input | 1 | Token from the previous device in the ring |
| flag_in_i | input | FLAG_W (4) | Per-queue flag values of this device |
| flag_o | output | FLAG_W (4) | Value for the shared flag bus |
| flag_oe_o | output | FLAG_W (4) | Per-bit output enable of the shared flag bus |
| sync_o | output | 1 | One-cycle marker of the ring master's turn |
| token_out_o | output | 1 | Token to the next device, high while owning |

## Verification
In addressed mode an ownership strobe and a queue selection can fall in the same cycle, and the bench provokes this by raising `qsel_i` with a strobe that would either grant or release the bus. A behavioural model in the bench, which treats such a strobe as void, is compared with the enables and bus value on every clock. The model therefore flags both a grant and a release that leak through. In ring mode the master's start-up claim and an incoming token fall on the same first edge, and the bench drives the token input high there to show that the start-up rule wins.

// File: rtl/fbo_pkg.sv
// Package: shared types for the flag-bus ownership controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fbo_pkg;

    // Ownership scheme picked while master reset is held.
    typedef enum logic {
        SCHEME_ADDRESSED = 1'b0,
        SCHEME_RING      = 1'b1
    } bus_scheme_e;

endpackage

// File: rtl/fbo_scheme_latch.sv
// Module: fbo_scheme_latch
// Captures the ownership scheme from the mode pin while reset is held and
// freezes it afterwards. Also marks the first cycle after reset release.
// Assumes: synchronous active-low reset held for at least one clock edge.
module fbo_scheme_latch
    import fbo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_i,
    output bus_scheme_e scheme_o,
    output logic        first_o
);

    bus_scheme_e scheme_q;
    logic        first_q;

    // Sample the mode pin during reset, hold it once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scheme_q <= mode_i ? SCHEME_RING : SCHEME_ADDRESSED;
        end
    end

    // Flag the first edge after reset release; cleared from then on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
        end
    end

    assign scheme_o = scheme_q;
    assign first_o  = first_q;

endmodule

// File: rtl/fbo_addr_select.sv
// Module: fbo_addr_select
// Addressed ownership: a valid strobe whose device field matches this
// device's identity grants the bus; a valid strobe for any other device
// releases it. A strobe coinciding with a queue selection is void.
// Assumes: enable_i is static after reset; ownership is cleared when disabled.
module fbo_addr_select #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable_i,
    input  logic [ID_W-1:0] dev_id_i,
    input  logic [ID_W-1:0] dev_addr_i,
    input  logic            strobe_i,
    input  logic            qsel_i,
    output logic            own_o
);

    logic own_q;
    logic hit;
    logic valid_strobe;

    // Decode whether this edge carries a usable selection and whether it is ours.
    always_comb begin
        valid_strobe = enable_i && strobe_i && !qsel_i;
        hit          = (dev_addr_i == dev_id_i);
    end

    // Update ownership on each valid selection, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= 1'b0;
        end else if (!enable_i) begin
            own_q <= 1'b0;
        end else if (valid_strobe) begin
            own_q <= hit;
        end
    end

    assign own_o = own_q;

endmodule

// File: rtl/fbo_ring_node.sv
// Module: fbo_ring_node
// Token-ring ownership: on the first edge after reset the master claims the
// bus; on later edges the node owns the bus when its token input is high.
// Assumes: exactly one device in the ring has master_i high.
module fbo_ring_node (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic first_i,
    input  logic master_i,
    input  logic token_in_i,
    output logic own_o
);

    logic own_q;
    logic claim;

    // Pick the claim source: start-up rule on the first edge, token after.
    always_comb begin
        if (first_i) begin
            claim = master_i;
        end else begin
            claim = token_in_i;
        end
    end

    // Register ownership for exactly one cycle per claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= 1'b0;
        end else if (!enable_i) begin
            own_q <= 1'b0;
        end else begin
            own_q <= claim;
        end
    end

    assign own_o = own_q;

endmodule

// File: rtl/fbo_bus_drive.sv
// Module: fbo_bus_drive
// Registers the per-queue flag values and gates them, bit by bit, onto the
// shared bus with matching output enables while this device owns the bus.
// Assumes: own_i is a registered signal aligned with the captured flags.
module fbo_bus_drive #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_i,
    input  logic [FLAG_W-1:0] flag_in_i,
    output logic [FLAG_W-1:0] flag_o,
    output logic [FLAG_W-1:0] flag_oe_o
);

    logic [FLAG_W-1:0] flag_q;

    // Capture the flag values every cycle so the bus shows last edge's state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_in_i;
        end
    end

    // One driver slice per bus bit: value and enable follow ownership.
    for (genvar b = 0; b < FLAG_W; b++) begin : g_slice
        always_comb begin
            flag_oe_o[b] = own_i;
            flag_o[b]    = own_i ? flag_q[b] : 1'b0;
        end
    end

endmodule

// File: rtl/flag_bus_owner.sv
// Module: flag_bus_owner (top)
// Decides whether this device drives the shared flag-status bus of a bank
// of cascaded devices, using either addressed selection or a token ring,
// as chosen by mode_i while reset is held.
// Assumes: every device in the bank uses the same scheme; in ring mode
// token_out_o of each device feeds token_in_i of the next, wrapping around.
module flag_bus_owner
    import fbo_pkg::*;
#(
    parameter int ID_W   = 3,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic [ID_W-1:0]   dev_id_i,
    input  logic [ID_W-1:0]   dev_addr_i,
    input  logic              strobe_i,
    input  logic              qsel_i,
    input  logic              master_i,
    input  logic              token_in_i,
    input  logic [FLAG_W-1:0] flag_in_i,
    output logic [FLAG_W-1:0] flag_o,
    output logic [FLAG_W-1:0] flag_oe_o,
    output logic              sync_o,
    output logic              token_out_o
);

    bus_scheme_e scheme;
    logic        first_cycle;
    logic        ring_mode;
    logic        addr_own;
    logic        ring_own;
    logic        own;

    fbo_scheme_latch u_scheme (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .scheme_o (scheme),
        .first_o  (first_cycle)
    );

    // Decode the latched scheme into a plain enable.
    always_comb begin
        ring_mode = (scheme == SCHEME_RING);
    end

    fbo_addr_select #(.ID_W(ID_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (!ring_mode),
        .dev_id_i   (dev_id_i),
        .dev_addr_i (dev_addr_i),
        .strobe_i   (strobe_i),
        .qsel_i     (qsel_i),
        .own_o      (addr_own)
    );

    fbo_ring_node u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (ring_mode),
        .first_i    (first_cycle),
        .master_i   (master_i),
        .token_in_i (token_in_i),
        .own_o      (ring_own)
    );

    // Merge the two ownership sources and derive the ring outputs.
    always_comb begin
        own         = ring_mode ? ring_own : addr_own;
        token_out_o = ring_mode && ring_own;
        sync_o      = ring_mode && ring_own && master_i;
    end

    fbo_bus_drive #(.FLAG_W(FLAG_W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_i     (own),
        .flag_in_i (flag_in_i),
        .flag_o    (flag_o),
        .flag_oe_o (flag_oe_o)
    );

endmodule

// File: rtl/fbo_checker.sv
// Module: fbo_checker
// Property checks on the ports of flag_bus_owner, bound to every instance.
// Keeps its own copy of the latched scheme and of the first-cycle marker.
module fbo_checker #(
    parameter int ID_W   = 3,
    parameter int FLAG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic [ID_W-1:0]   dev_id_i,
    input logic [ID_W-1:0]   dev_addr_i,
    input logic              strobe_i,
    input logic              qsel_i,
    input logic              master_i,
    input logic              token_in_i,
    input logic [FLAG_W-1:0] flag_o,
    input logic [FLAG_W-1:0] flag_oe_o,
    input logic              sync_o,
    input logic              token_out_o
);

    logic ring_q;
    logic post_q;

    // Track the scheme seen during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= mode_i;
        end
    end

    // Track whether the first edge after release has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_q <= 1'b0;
        end else begin
            post_q <= 1'b1;
        end
    end

    p_addr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_q |-> (!token_out_o && !sync_o));

    p_addr_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_q && strobe_i && !qsel_i && dev_addr_i == dev_id_i) |=> (&flag_oe_o));

    p_addr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_q && strobe_i && !qsel_i && dev_addr_i != dev_id_i) |=> (flag_oe_o == '0));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_q && post_q && !strobe_i) |=> $stable(flag_oe_o));

    p_qsel_void_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_q && post_q && qsel_i) |=> $stable(flag_oe_o));

    p_master_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q && !post_q && master_i) |=> (token_out_o && sync_o));

    p_slave_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q && !post_q && !master_i) |=> !token_out_o);

    p_ring_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q && post_q && token_in_i) |=> token_out_o);

    p_ring_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q && post_q && !token_in_i) |=> !token_out_o);

    p_sync_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (ring_q && master_i && token_out_o));

    p_oe_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flag_oe_o) == 0) || (&flag_oe_o));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_oe_o == '0) |-> (flag_o == '0));

endmodule

bind flag_bus_owner fbo_checker #(.ID_W(ID_W), .FLAG_W(FLAG_W)) u_fbo_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .dev_id_i    (dev_id_i),
    .dev_addr_i  (dev_addr_i),
    .strobe_i    (strobe_i),
    .qsel_i      (qsel_i),
    .master_i    (master_i),
    .token_in_i  (token_in_i),
    .flag_o      (flag_o),
    .flag_oe_o   (flag_oe_o),
    .sync_o      (sync_o),
    .token_out_o (token_out_o)
);

// File: tb/flag_bus_owner_tb_top.sv
// Bench: behavioural reference model compared with the DUT on every clock.
module flag_bus_owner_tb_top;

    localparam int ID_W   = 3;
    localparam int FLAG_W = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mode_i;
    logic [ID_W-1:0]   dev_id_i;
    logic [ID_W-1:0]   dev_addr_i;
    logic              strobe_i;
    logic              qsel_i;
    logic              master_i;
    logic              token_in_i;
    logic [FLAG_W-1:0] flag_in_i;
    logic [FLAG_W-1:0] flag_o;
    logic [FLAG_W-1:0] flag_oe_o;
    logic              sync_o;
    logic              token_out_o;

    always #5 clk = ~clk;

    flag_bus_owner #(.ID_W(ID_W), .FLAG_W(FLAG_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .dev_id_i    (dev_id_i),
        .dev_addr_i  (dev_addr_i),
        .strobe_i    (strobe_i),
        .qsel_i      (qsel_i),
        .master_i    (master_i),
        .token_in_i  (token_in_i),
        .flag_in_i   (flag_in_i),
        .flag_o      (flag_o),
        .flag_oe_o   (flag_oe_o),
        .sync_o      (sync_o),
        .token_out_o (token_out_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    cmp_en = 0;
    bit    done   = 0;
    string tag    = "R2";

    // Reference model state.
    bit                m_ring;
    bit                m_first;
    bit                m_own;
    logic [FLAG_W-1:0] m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ring  = mode_i;
            m_first = 1'b1;
            m_own   = 1'b0;
            m_flag  = '0;
        end else begin
            if (!m_ring) begin
                if (strobe_i && !qsel_i) m_own = (dev_addr_i == dev_id_i);
            end else begin
                m_own = m_first ? master_i : token_in_i;
            end
            m_first = 1'b0;
            m_flag  = flag_in_i;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on the falling edge, well away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("oe R9", 32'(flag_oe_o), m_own ? 32'((1 << FLAG_W) - 1) : 32'd0);
            chk("bus R9", 32'(flag_o), m_own ? 32'(m_flag) : 32'd0);
            chk("token R7", 32'(token_out_o), 32'(m_ring && m_own));
            chk("sync R8", 32'(sync_o), 32'(m_ring && m_own && master_i));
        end
    end

    // Watchdog: an expired run is a failed check and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic start(input bit mode, input bit master);
        rst_n    = 1'b0;
        mode_i   = mode;
        master_i = master;
        strobe_i = 1'b0;
        qsel_i   = 1'b0;
        token_in_i = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic sel(input logic [ID_W-1:0] a, input bit q);
        dev_addr_i = a;
        strobe_i   = 1'b1;
        qsel_i     = q;
        flag_in_i  = flag_in_i + 4'd3;
        tick();
        strobe_i = 1'b0;
        qsel_i   = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; mode_i = 1'b0; dev_id_i = 3'd5; dev_addr_i = '0;
        strobe_i = 1'b0; qsel_i = 1'b0; master_i = 1'b0; token_in_i = 1'b0;
        flag_in_i = 4'h6;
        tick(); tick();
        cmp_en = 1;

        // Addressed scheme.
        tag = "R2"; start(1'b0, 1'b1); repeat (3) tick();
        tag = "R1"; mode_i = 1'b1; token_in_i = 1'b1; repeat (3) tick(); token_in_i = 1'b0;
        tag = "R4"; sel(3'd2, 1'b0); tick();
        tag = "R3"; sel(3'd5, 1'b0);
        tag = "R9"; for (int i = 0; i < 5; i++) begin flag_in_i = 4'(i * 5 + 1); tick(); end
        tag = "R4"; repeat (2) tick();
        tag = "R5"; sel(3'd1, 1'b1); tick();
        tag = "R4"; sel(3'd1, 1'b0); tick();
        tag = "R5"; sel(3'd5, 1'b1); tick();
        tag = "R10"; for (int i = 0; i < 6; i++) sel(i[0] ? 3'd7 : 3'd5, 1'b0);
        tick();

        // Ring scheme, master device; token high on the first edge too.
        tag = "R6"; start(1'b1, 1'b1); token_in_i = 1'b1; tick(); token_in_i = 1'b0; tick();
        tag = "R7"; repeat (3) tick(); token_in_i = 1'b1; tick(); token_in_i = 1'b0;
        repeat (2) tick();
        tag = "R8"; for (int i = 0; i < 8; i++) begin token_in_i = (i % 3 == 0); tick(); end
        tag = "R10"; token_in_i = 1'b1; repeat (3) tick(); token_in_i = 1'b0; tick();
        tag = "R1"; mode_i = 1'b0; sel(3'd5, 1'b0); tick();

        // Ring scheme, non-master device.
        tag = "R6"; start(1'b1, 1'b0); token_in_i = 1'b1; tick(); token_in_i = 1'b0; tick();
        tag = "R7"; for (int i = 0; i < 10; i++) begin token_in_i = (i % 4 == 1); flag_in_i = 4'(i); tick(); end
        tag = "R8"; token_in_i = 1'b1; repeat (2) tick(); token_in_i = 1'b0; tick();

        // Back to addressed scheme after a fresh reset.
        tag = "R1"; start(1'b0, 1'b0); tick();
        tag = "R3"; sel(3'd5, 1'b0); tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule